// File: doc/BRIEF.md
# Processor Interrupt Output Bypass Stage

This block is the last stage of a processor-facing interrupt controller interface. It decides what drives the IRQ and FIQ lines into one core. A line can be driven by the interface itself, from the group-0 and group-1 requests that the prioritisation logic has already selected. A line the interface does not drive can instead pass the matching legacy input pin straight through, or be held inactive.

A small control register, written and read over a plain register port, holds the group enables, the group-0 routing choice and four bypass-disable bits. There is one bypass-disable bit for each pairing of output line and group. Turning the interface off therefore does not mask interrupts: the legacy pins still reach the core unless the bypass-disable bits block them. A separate pair of wake outputs reports pending requests to a power controller. These outputs ignore the enable and bypass-disable bits, so a core that has shut its interface can still be woken. All four outputs are registered.

Top module: `irq_egress`

## Requirements
- R1: While reset is asserted, and on the first clock after it, the control register reads zero and all four outputs are low, whatever the legacy pins do.
- R2: When a line is not driven by the interface and both bypass-disable bits for that line are clear, the line follows its legacy input pin (IRQ follows legacy IRQ, FIQ follows legacy FIQ).
- R3: When a line is not driven and any of its two bypass-disable bits is set, the line is held low. For FIQ these bits are bit 5 (group 0) and bit 7 (group 1). For IRQ they are bit 6 (group 0) and bit 8 (group 1). Writing 0x1E0 sets all four bits and clears both enables.
- R4: Bit 0 enables group 0 and bit 1 enables group 1. Bit 3 set routes group 0 to FIQ; bit 3 clear routes it to IRQ. Group 1 always goes to IRQ. A line is driven when an enabled group is routed to it. A driven line equals the OR of the requests of the enabled groups routed to it, and its legacy pin has no effect.
- R5: The wake IRQ output is high when the group-1 request is present, or when the group-0 request is present with bit 3 clear. The wake FIQ output is high when the group-0 request is present with bit 3 set. Enable and bypass-disable bits never affect either wake output.
- R6: Only bits 0, 1, 3 and 5 to 8 are stored, so a full write of ones reads back as 0x1EB. Every other bit reads zero and ignores writes.
- R7: Any change of the control register or of an input reaches the outputs on the next rising clock edge, not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr_en | input | 1 | Write strobe for the control register |
| reg_wr_data | input | CTRL_W | Write data |
| reg_rd_data | output | CTRL_W | Control register contents |
| req_g0 | input | 1 | Signalled group-0 request |
| req_g1 | input | 1 | Signalled group-1 request |
| legacy_irq | input | 1 | Legacy IRQ pin |
| legacy_fiq | input | 1 | Legacy FIQ pin |
| core_irq | output | 1 | IRQ line to the core |
| core_fiq | output | 1 | FIQ line to the core |
| wake_irq | output | 1 | Wake IRQ to the power controller |
| wake_fiq | output | 1 | Wake FIQ to the power controller |

## Verification
The bench uses the default 16-bit register width. This leaves seven spare bits above bit 8, so a write of all ones shows that the unused bits, including the gap at bits 2 and 4, are neither stored nor able to disturb the lines. One bypass-disable bit is set at a time to show which line each bit holds low. Both routing choices of group 0 are covered, as is the case of a line that is undriven while the other line is driven.

// File: rtl/irq_egress_pkg.sv
package irq_egress_pkg;

   localparam int unsigned B_EN0   = 0;
   localparam int unsigned B_EN1   = 1;
   localparam int unsigned B_G0FIQ = 3;
   localparam int unsigned B_FBD0  = 5;
   localparam int unsigned B_IBD0  = 6;
   localparam int unsigned B_FBD1  = 7;
   localparam int unsigned B_IBD1  = 8;
   localparam int unsigned MIN_W   = 9;
   localparam logic [8:0]  KEEP_MASK = 9'h1EB;

   typedef struct packed {
      logic en0;
      logic en1;
      logic g0_to_fiq;
      logic fiq_bd0;
      logic irq_bd0;
      logic fiq_bd1;
      logic irq_bd1;
   } ctrl_t;

endpackage

// File: rtl/irq_egress_ctrl.sv
module irq_egress_ctrl
   import irq_egress_pkg::*;
#(
   parameter int unsigned CTRL_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [CTRL_W-1:0] wr_data,
   output logic [CTRL_W-1:0] rd_data,
   output ctrl_t             ctrl
);
   localparam logic [CTRL_W-1:0] MASK = CTRL_W'(KEEP_MASK);

   logic [CTRL_W-1:0] ctrl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ctrl_q <= '0;
      else if (wr_en)
         ctrl_q <= wr_data & MASK;
   end

   assign rd_data = ctrl_q;

   always_comb begin
      ctrl.en0       = ctrl_q[B_EN0];
      ctrl.en1       = ctrl_q[B_EN1];
      ctrl.g0_to_fiq = ctrl_q[B_G0FIQ];
      ctrl.fiq_bd0   = ctrl_q[B_FBD0];
      ctrl.irq_bd0   = ctrl_q[B_IBD0];
      ctrl.fiq_bd1   = ctrl_q[B_FBD1];
      ctrl.irq_bd1   = ctrl_q[B_IBD1];
   end

   // R6: bits outside the kept set never hold a one
   p_spare_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data & ~MASK) == '0);

   // R1: the register comes out of reset cleared
   p_reset_clear_r1: assert property (@(posedge clk)
      $rose(rst_n) |-> rd_data == '0);
endmodule

// File: rtl/irq_egress_line.sv
module irq_egress_line
   import irq_egress_pkg::*;
#(
   parameter bit IS_FIQ = 1'b0
) (
   input  ctrl_t ctrl,
   input  logic  req0,
   input  logic  req1,
   input  logic  legacy,
   output logic  line_nxt,
   output logic  wake_nxt
);
   logic route0, route1, bd0, bd1;
   logic driven, drv_val;

   generate
      if (IS_FIQ) begin : g_fiq
         assign route0 = ctrl.g0_to_fiq;
         assign route1 = 1'b0;
         assign bd0    = ctrl.fiq_bd0;
         assign bd1    = ctrl.fiq_bd1;
      end else begin : g_irq
         assign route0 = ~ctrl.g0_to_fiq;
         assign route1 = 1'b1;
         assign bd0    = ctrl.irq_bd0;
         assign bd1    = ctrl.irq_bd1;
      end
   endgenerate

   always_comb begin
      driven   = (ctrl.en0 & route0) | (ctrl.en1 & route1);
      drv_val  = (ctrl.en0 & route0 & req0) | (ctrl.en1 & route1 & req1);
      line_nxt = driven ? drv_val : (legacy & ~(bd0 | bd1));
      wake_nxt = (route0 & req0) | (route1 & req1);
   end
endmodule

// File: rtl/irq_egress.sv
module irq_egress
   import irq_egress_pkg::*;
#(
   parameter int unsigned CTRL_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr_en,
   input  logic [CTRL_W-1:0] reg_wr_data,
   output logic [CTRL_W-1:0] reg_rd_data,
   input  logic              req_g0,
   input  logic              req_g1,
   input  logic              legacy_irq,
   input  logic              legacy_fiq,
   output logic              core_irq,
   output logic              core_fiq,
   output logic              wake_irq,
   output logic              wake_fiq
);
   localparam int unsigned NLINE = 2;

   generate
      if (CTRL_W < MIN_W) begin : g_bad_width
         $error("irq_egress: CTRL_W must be at least 9");
      end
   endgenerate

   ctrl_t            ctrl;
   logic [NLINE-1:0] legacy_v, line_nxt, wake_nxt;
   logic [NLINE-1:0] line_q, wake_q;

   irq_egress_ctrl #(.CTRL_W(CTRL_W)) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (reg_wr_en),
      .wr_data (reg_wr_data),
      .rd_data (reg_rd_data),
      .ctrl    (ctrl)
   );

   assign legacy_v = {legacy_fiq, legacy_irq};

   // index 0 is IRQ, index 1 is FIQ
   for (genvar i = 0; i < NLINE; i++) begin : g_line
      irq_egress_line #(.IS_FIQ(i == 1)) u_line (
         .ctrl     (ctrl),
         .req0     (req_g0),
         .req1     (req_g1),
         .legacy   (legacy_v[i]),
         .line_nxt (line_nxt[i]),
         .wake_nxt (wake_nxt[i])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         line_q <= '0;
         wake_q <= '0;
      end else begin
         line_q <= line_nxt;
         wake_q <= wake_nxt;
      end
   end

   assign core_irq = line_q[0];
   assign core_fiq = line_q[1];
   assign wake_irq = wake_q[0];
   assign wake_fiq = wake_q[1];

   // R5: a group-1 request always shows on wake IRQ one cycle later
   p_wake_g1_r5: assert property (@(posedge clk) disable iff (!rst_n)
      req_g1 |=> wake_irq);

   // R5: with no request pending, no wake output rises
   p_wake_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!req_g0 && !req_g1) |=> (!wake_irq && !wake_fiq));

   // R2: a cleared register passes both legacy pins through
   p_bypass_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd_data == '0) |=> (core_irq == $past(legacy_irq) &&
                               core_fiq == $past(legacy_fiq)));

   // R3: an undriven FIQ with a FIQ bypass-disable bit set stays low
   p_fiq_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!(reg_rd_data[B_EN0] && reg_rd_data[B_G0FIQ]) &&
       (reg_rd_data[B_FBD0] || reg_rd_data[B_FBD1])) |=> !core_fiq);
endmodule

// File: tb/irq_egress_tb_top.sv
module irq_egress_tb_top;
   localparam int unsigned W = 16;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         reg_wr_en = 1'b0;
   logic [W-1:0] reg_wr_data = '0;
   logic [W-1:0] reg_rd_data;
   logic         req_g0 = 1'b0, req_g1 = 1'b0;
   logic         legacy_irq = 1'b0, legacy_fiq = 1'b0;
   logic         core_irq, core_fiq, wake_irq, wake_fiq;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   irq_egress #(.CTRL_W(W)) dut_i (
      .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data),
      .reg_rd_data(reg_rd_data), .req_g0(req_g0), .req_g1(req_g1),
      .legacy_irq(legacy_irq), .legacy_fiq(legacy_fiq), .core_irq(core_irq),
      .core_fiq(core_fiq), .wake_irq(wake_irq), .wake_fiq(wake_fiq));

   // {ctrl[8:0], req_g0, req_g1, legacy_irq, legacy_fiq, irq, fiq, wake_irq, wake_fiq}
   localparam int NV = 11;
   localparam logic [16:0] VEC [NV] = '{
      {9'h000, 4'b0011, 4'b1100},   // R2 full bypass
      {9'h1E0, 4'b0011, 4'b0000},   // R3 all disables
      {9'h1E0, 4'b1111, 4'b0010},   // R5 wake live while off
      {9'h003, 4'b1001, 4'b1110},   // R4 g0 on IRQ, FIQ bypassed
      {9'h00B, 4'b1010, 4'b0101},   // R4 g0 on FIQ, IRQ driven low
      {9'h00A, 4'b0101, 4'b1110},   // R4 only g1 enabled
      {9'h020, 4'b0011, 4'b1000},   // R3 bit 5
      {9'h080, 4'b0011, 4'b1000},   // R3 bit 7
      {9'h040, 4'b0011, 4'b0100},   // R3 bit 6
      {9'h100, 4'b0011, 4'b0100},   // R3 bit 8
      {9'h009, 4'b0111, 4'b1010}    // R4 FIQ driven low, IRQ bypassed
   };

   task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic write_ctrl(input logic [W-1:0] v);
      @(negedge clk);
      reg_wr_en   = 1'b1;
      reg_wr_data = v;
      @(negedge clk);
      reg_wr_en   = 1'b0;
   endtask

   initial begin : watchdog
      repeat (5000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin : main
      legacy_irq = 1'b1;
      legacy_fiq = 1'b1;
      repeat (3) @(negedge clk);
      // R1: in reset, outputs low despite active legacy pins
      check("R1 outputs", W'({core_irq, core_fiq, wake_irq, wake_fiq}), W'(0));
      check("R1 register", reg_rd_data, W'(0));
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 first clock", W'(reg_rd_data), W'(0));

      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         reg_wr_en   = 1'b1;
         reg_wr_data = W'(VEC[i][16:8]);
         {req_g0, req_g1, legacy_irq, legacy_fiq} = VEC[i][7:4];
         @(negedge clk);
         reg_wr_en = 1'b0;
         @(negedge clk);
         check($sformatf("R2/R3/R4/R5 vector %0d", i),
               W'({core_irq, core_fiq, wake_irq, wake_fiq}), W'(VEC[i][3:0]));
      end

      // R6: only the kept bits store
      write_ctrl('1);
      check("R6 readback", reg_rd_data, W'(16'h01EB));
      write_ctrl(W'(16'hFE14));
      check("R6 spare bits ignored", reg_rd_data, W'(0));

      // R7: one-clock latency, legacy passes through with a clear register
      req_g0 = 1'b0; req_g1 = 1'b0; legacy_irq = 1'b1; legacy_fiq = 1'b0;
      @(negedge clk); @(negedge clk);
      check("R7 settled", W'({core_irq, core_fiq}), W'(2'b10));
      legacy_irq = 1'b0;
      legacy_fiq = 1'b1;
      #0.5;
      check("R7 no early change", W'({core_irq, core_fiq}), W'(2'b10));
      @(negedge clk);
      check("R7 after one edge", W'({core_irq, core_fiq}), W'(2'b01));

      // R7: register write takes effect on the outputs one edge after storing
      @(negedge clk);
      reg_wr_en = 1'b1;
      reg_wr_data = W'(16'h01E0);
      @(negedge clk);
      reg_wr_en = 1'b0;
      check("R7 write not yet visible", W'(core_fiq), W'(1));
      @(negedge clk);
      check("R3 write 0x1E0 holds FIQ", W'(core_fiq), W'(0));

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule